// File: doc/BRIEF.md
# Unordered Double-Precision Compare Unit

This block compares two IEEE-754 binary64 operands and reports how they are ordered. It is meant to sit in a floating-point pipeline. The issue logic presents both operands with a valid strobe. One clock later the unit returns three things: a 4-bit condition nibble, a 5-bit result-class code for the status register together with its write enable, and set pulses for the signalling-NaN sticky flag and for the exception summary bit.

NaN handling follows the unordered rules. Any NaN operand yields only the unordered indication. No invalid-compare exception is ever raised. Only a signalling NaN raises a status flag. Ordering uses the full 64-bit values, so single-precision data held in double format needs no extra handling. The two zeros compare equal.

Control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_EMIT` means a result is on the outputs for exactly one cycle. The transitions are:
- IDLE→EMIT when the valid strobe is high.
- EMIT→EMIT when a new operand pair arrives back to back.
- EMIT→IDLE when the strobe is low.
- IDLE→IDLE when the strobe is low.

Top module: `fcmp_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the condition nibble is 4'b0001: unordered set, and less, greater and equal clear.
- R2: If neither operand is a NaN, exactly one of less (A<B), greater (A>B) or equal is set, and unordered is clear.
- R3: Condition nibble layout: bit 3 = less, bit 2 = greater, bit 1 = equal, bit 0 = unordered.
- R4: The result-class code is 5'b01000 for less, 5'b00100 for greater, 5'b00010 for equal and 5'b00001 for unordered. Bit 4 is always 0. `flags_we` is high exactly when a result is presented.
- R5: A signalling NaN (NaN whose fraction bit 51 is 0) on either input gives `snan_set` = 1 with the result. A quiet NaN (fraction bit 51 = 1) alone gives `snan_set` = 0.
- R6: +0 and -0 compare equal in both pairings.
- R7: `summary_set` pulses whenever `snan_set` pulses, and is otherwise 0.
- R8: Results appear on the clock edge after a cycle with `in_valid` high, with `res_valid` = 1 for that one cycle. After a cycle with `in_valid` low, `res_valid`, `flags_we`, `snan_set` and `summary_set` are 0 and the nibble and code read 0, whatever the operands.
- R9: During and right after reset, all outputs are 0.
- R10: Non-NaN ordering is numeric. Negative values reverse the magnitude order, infinities order beyond every finite value, and denormals order by their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair valid strobe |
| opnd_a | input | 64 | Operand A, binary64 |
| opnd_b | input | 64 | Operand B, binary64 |
| res_valid | output | 1 | Result presented this cycle |
| cond_nib | output | 4 | {less, greater, equal, unordered} |
| flags_code | output | 5 | Result-class code for the status register |
| flags_we | output | 1 | Write enable for flags_code |
| snan_set | output | 1 | Set pulse for the signalling-NaN sticky flag |
| summary_set | output | 1 | Set pulse for the exception summary bit |

## Verification
The bench targets the cases where sign-magnitude ordering goes wrong:
- The two zeros. A plain bit compare would report -0 as less than +0.
- Pairs of negative numbers. Forgetting to reverse the order would swap less and greater.
- The largest and smallest denormals and the infinities. A broken magnitude compare would misorder these at the edges of the exponent range.
- NaNs of both kinds on each input. Mixing up quiet and signalling would raise a spurious sticky flag, or miss a real one.
- Cycles with the strobe low. These expose pulses that are not qualified by the strobe.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fcmp_state_e;

    localparam int CB_LT = 3;
    localparam int CB_GT = 2;
    localparam int CB_EQ = 1;
    localparam int CB_UN = 0;

    function automatic logic [4:0] class_code(input logic [3:0] nib);
        logic [4:0] code;
        code = 5'b00000;
        if (nib[CB_UN])      code = 5'b00001;
        else if (nib[CB_LT]) code = 5'b01000;
        else if (nib[CB_GT]) code = 5'b00100;
        else if (nib[CB_EQ]) code = 5'b00010;
        return code;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MAG_W  = EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] opnd,
    output logic              sign,
    output logic              is_nan,
    output logic              is_snan,
    output logic              is_zero,
    output logic [MAG_W-1:0]  mag
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        sign    = opnd[WORD_W-1];
        expo    = opnd[MAG_W-1:FRAC_W];
        frac    = opnd[FRAC_W-1:0];
        mag     = opnd[MAG_W-1:0];
        is_nan  = (&expo) && (|frac);
        is_snan = is_nan && !frac[FRAC_W-1];
        is_zero = (mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int MAG_W = 63
) (
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic             zero_a,
    input  logic             zero_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output logic             lt,
    output logic             gt,
    output logic             eq
);
    logic mag_lt, mag_gt;

    always_comb begin
        mag_lt = (mag_a < mag_b);
        mag_gt = (mag_a > mag_b);
        lt = 1'b0;
        gt = 1'b0;
        eq = 1'b0;
        if (zero_a && zero_b) begin
            eq = 1'b1;
        end else if (sign_a != sign_b) begin
            lt = sign_a;
            gt = sign_b;
        end else if (sign_a) begin
            lt = mag_gt;
            gt = mag_lt;
            eq = !mag_lt && !mag_gt;
        end else begin
            lt = mag_lt;
            gt = mag_gt;
            eq = !mag_lt && !mag_gt;
        end
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MAG_W  = EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output logic              res_valid,
    output logic [3:0]        cond_nib,
    output logic [4:0]        flags_code,
    output logic              flags_we,
    output logic              snan_set,
    output logic              summary_set
);
    logic [WORD_W-1:0] opnd [2];
    logic [1:0]        sgn, nan, snan, zero;
    logic [MAG_W-1:0]  mag [2];

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .opnd    (opnd[gi]),
            .sign    (sgn[gi]),
            .is_nan  (nan[gi]),
            .is_snan (snan[gi]),
            .is_zero (zero[gi]),
            .mag     (mag[gi])
        );
    end

    logic ord_lt, ord_gt, ord_eq;

    fcmp_order #(.MAG_W(MAG_W)) u_ord (
        .sign_a (sgn[0]),
        .sign_b (sgn[1]),
        .zero_a (zero[0]),
        .zero_b (zero[1]),
        .mag_a  (mag[0]),
        .mag_b  (mag[1]),
        .lt     (ord_lt),
        .gt     (ord_gt),
        .eq     (ord_eq)
    );

    logic [3:0] cond_d;
    always_comb begin
        cond_d = 4'b0000;
        if (|nan) begin
            cond_d[CB_UN] = 1'b1;
        end else begin
            cond_d[CB_LT] = ord_lt;
            cond_d[CB_GT] = ord_gt;
            cond_d[CB_EQ] = ord_eq;
        end
    end

    fcmp_state_e state_q, state_d;
    logic [3:0]  cond_q;
    logic        snan_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cond_q  <= 4'b0000;
            snan_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                cond_q <= cond_d;
                snan_q <= |snan;
            end
        end
    end

    always_comb begin
        res_valid   = (state_q == ST_EMIT);
        cond_nib    = res_valid ? cond_q : 4'b0000;
        flags_code  = res_valid ? class_code(cond_q) : 5'b00000;
        flags_we    = res_valid;
        snan_set    = res_valid && snan_q;
        summary_set = snan_set;
    end

    AST_UNORD_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_nib[CB_UN] |-> (cond_nib[3:1] == 3'b000)); // R1
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(cond_nib) == 1)); // R2
    AST_CODE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_code[4]); // R4
    AST_CODE_TRACKS_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flags_code[3:0] == cond_nib)); // R4
    AST_SNAN_IN_A: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&opnd_a[WORD_W-2:FRAC_W]) && !opnd_a[FRAC_W-1]
         && (|opnd_a[FRAC_W-2:0])) |=> snan_set); // R5
    AST_SNAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        snan_set |-> cond_nib[CB_UN]); // R5
    AST_FX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        snan_set |-> summary_set); // R7
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid); // R8
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!flags_we && !snan_set && !summary_set)); // R8
endmodule

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        res_valid, flags_we, snan_set, summary_set;
    logic [3:0]  cond_nib;
    logic [4:0]  flags_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [3:0] q_cond [$];
    bit         q_snan [$];
    string      q_tag  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_unit u_fcmp_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_valid(res_valid), .cond_nib(cond_nib), .flags_code(flags_code),
        .flags_we(flags_we), .snan_set(snan_set), .summary_set(summary_set)
    );

    function automatic bit ref_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    function automatic bit ref_snan(input logic [63:0] v);
        return ref_nan(v) && !v[51];
    endfunction

    function automatic logic [4:0] ref_code(input logic [3:0] c);
        case (c)
            4'b1000: return 5'b01000;
            4'b0100: return 5'b00100;
            4'b0010: return 5'b00010;
            default: return 5'b00001;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input string tag);
        logic [3:0] c;
        real ra, rb;
        @(negedge clk);
        in_valid = 1'b1;
        opnd_a = a;
        opnd_b = b;
        if (ref_nan(a) || ref_nan(b)) begin
            c = 4'b0001;
        end else begin
            ra = $bitstoreal(a);
            rb = $bitstoreal(b);
            if (ra < rb)      c = 4'b1000;
            else if (ra > rb) c = 4'b0100;
            else              c = 4'b0010;
        end
        q_cond.push_back(c);
        q_snan.push_back(ref_snan(a) || ref_snan(b));
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n, input logic [63:0] a, input logic [63:0] b);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opnd_a = a;
            opnd_b = b;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                if (q_cond.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R8 actual=unexpected result expected=none");
                end else begin
                    logic [3:0] ec;
                    bit es;
                    string t;
                    ec = q_cond.pop_front();
                    es = q_snan.pop_front();
                    t  = q_tag.pop_front();
                    check({t, " nibble R3"}, {28'h0, cond_nib}, {28'h0, ec});
                    check({t, " code R4"}, {27'h0, flags_code}, {27'h0, ref_code(ec)});
                    check({t, " we R4"}, {31'h0, flags_we}, 32'h1);
                    check({t, " snan R5"}, {31'h0, snan_set}, {31'h0, es});
                    check({t, " summary R7"}, {31'h0, summary_set}, {31'h0, es});
                end
            end else begin
                check("idle outputs R8",
                      {22'h0, flags_we, snan_set, summary_set, cond_nib, flags_code},
                      32'h0);
            end
        end
    end

    localparam logic [63:0] P_ZERO  = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N_ZERO  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] P_INF   = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF   = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] DN_MAX  = 64'h000F_FFFF_FFFF_FFFF;
    localparam logic [63:0] DN_MIN  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] ONE     = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO     = 64'h4000_0000_0000_0000;
    localparam logic [63:0] M_ONE   = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] M_TWO   = 64'hC000_0000_0000_0000;
    localparam logic [63:0] QNAN    = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] SNAN    = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] SNAN_N  = 64'hFFF4_0000_0000_0000;

    function automatic logic [63:0] rnd_finite();
        logic [63:0] v;
        v = {$urandom, $urandom};
        if (v[62:52] == 11'h7FF) v[62:52] = 11'h7FE;
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("reset outputs R9",
              {21'h0, res_valid, flags_we, snan_set, summary_set, cond_nib, flags_code},
              32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        check("post-reset outputs R9",
              {21'h0, res_valid, flags_we, snan_set, summary_set, cond_nib, flags_code},
              32'h0);

        drive(P_ZERO, N_ZERO, "+0 vs -0 R6");
        drive(N_ZERO, P_ZERO, "-0 vs +0 R6");
        drive(ONE, TWO, "1<2 R2");
        drive(TWO, ONE, "2>1 R2");
        drive(ONE, ONE, "1==1 R2");
        drive(M_ONE, M_TWO, "-1>-2 R10");
        drive(M_TWO, M_ONE, "-2<-1 R10");
        drive(P_INF, DN_MAX, "+inf>denorm R10");
        drive(N_INF, M_TWO, "-inf<-2 R10");
        drive(P_INF, P_INF, "inf==inf R10");
        drive(DN_MAX, DN_MIN, "denorm max>min R10");
        drive(DN_MIN, P_ZERO, "denorm min>0 R10");
        drive(DN_MIN | N_ZERO, P_ZERO, "-denorm<0 R10");
        idle(2, SNAN, SNAN);
        drive(QNAN, ONE, "qnan A R1");
        drive(ONE, QNAN, "qnan B R1");
        drive(SNAN, ONE, "snan A R5");
        drive(ONE, SNAN_N, "snan B R5");
        drive(QNAN, SNAN, "q+s nan R5");
        drive(P_INF, QNAN, "inf vs qnan R1");
        idle(3, SNAN, QNAN);
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b;
            a = rnd_finite();
            b = (i % 7 == 0) ? a : rnd_finite();
            if (i % 5 == 0) b[63] = ~a[63];
            drive(a, b, "random R10");
            if (i % 11 == 0) idle(1, a, b);
        end
        idle(4, P_ZERO, P_ZERO);
        check("queue drained R8", q_cond.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule